// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Register

This block watches sixteen general interrupt request lines and two non-maskable lines. It records edge events on them in sticky status flags. Each line has two enable bits of its own, one for rising edges and one for falling edges. Setting both makes the line respond to either direction. Each raw input is synchronized to the block clock before edge detection. A flag is set when an edge of an enabled direction is seen. It then stays set until software clears it or a DMA service acknowledge for that line arrives.

Software reaches the flags and the four per-line configuration registers through a simple word-addressed register bus. Reads are combinational from the address. Writes are single-cycle strobes. The flag register is write-one-to-clear. Two per-line masks decide where a set flag goes. The interrupt mask gates the interrupt request output. The DMA select mask gates the DMA request output. Neither mask has any effect on whether a flag gets captured.

Line numbering is used the same way in every register and every output vector. Bits 0 to 15 are the general lines. Bit 16 is non-maskable line 0 and bit 17 is non-maskable line 1.

Top module: `edge_irq_flags`

## Requirements
- R1: After reset, all flags, both edge-enable registers, the interrupt mask and the DMA select mask are zero, and irqOut and dmaReq are zero.
- R2: A rising edge on a line whose rising enable is 1 sets that line's flag. If the input changes between two clock edges, the flag reads 1 after the third rising clock edge that follows, and still reads 0 after the second.
- R3: A falling edge on a line whose falling enable is 1 sets that line's flag with the same three-edge latency.
- R4: An edge whose direction is not enabled on that line leaves the flag unchanged.
- R5: With both enables set on a line, the flag is set by a rising edge and also by a falling edge.
- R6: A flag is captured whatever the interrupt mask bit holds. irqOut bit i is flag i AND interrupt mask bit i.
- R7: dmaReq bit i is flag i AND DMA select bit i. The DMA select mask does not affect flag capture.
- R8: A bus write to word address 0 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 are unchanged.
- R9: A one-cycle pulse on dmaAck bit i clears flag i only.
- R10: If a qualifying edge and a clear (bus or DMA acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R11: busRdData returns the register at busAddr: 0 flags, 1 rising enables, 2 falling enables, 3 interrupt mask, 4 DMA select. Addresses 5 to 7 read as zero. Writes to addresses 1 to 4 load the register on the next clock edge.
- R12: A set flag stays set, whatever the input does, until it is cleared as in R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 16 | Raw general interrupt request lines (lines 0 to 15) |
| nmiIn | input | 2 | Raw non-maskable lines (lines 16 and 17) |
| busAddr | input | 3 | Register word address |
| busWrEn | input | 1 | Single-cycle write strobe |
| busWrData | input | 18 | Write data, one bit per line |
| busRdData | output | 18 | Read data for busAddr, one bit per line |
| dmaAck | input | 18 | Per-line DMA service acknowledge pulses |
| irqOut | output | 18 | Per-line interrupt requests |
| dmaReq | output | 18 | Per-line DMA requests |

## Verification
A wrong flag bit shows up in the same cycle on the flag readback. It also shows on irqOut or dmaReq when that line's mask bit is set. A miscounted synchronizer stage moves the first flag readback by one cycle, and the bench checks the cycle before and the cycle of capture. A wrong clear priority or a clear that leaks to other lines shows on the readback on the very next edge. A wrong enable register can stay hidden until an edge of the affected direction arrives, so enables are also read back directly.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  localparam int unsigned NUM_REGS   = 5;
  localparam int unsigned ADDR_FLAGS = 0;
  localparam int unsigned ADDR_RISE  = 1;
  localparam int unsigned ADDR_FALL  = 2;
  localparam int unsigned ADDR_IRQEN = 3;
  localparam int unsigned ADDR_DMA   = 4;

  typedef struct packed {
    logic                clrFlags;
    logic                wrRise;
    logic                wrFall;
    logic                wrIrqEn;
    logic                wrDmaSel;
    logic [NUM_REGS-1:0] rdHit;
  } ctrlStrobe_t;

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int unsigned WIDTH  = 18,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
    end else begin
      stageQ[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobe_t       strobe
);

  logic [NUM_REGS-1:0] hit;

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      hit[r] = (busAddr == ADDR_W'(r));
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.rdHit    = hit;
    strobe.clrFlags = busWrEn & hit[ADDR_FLAGS];
    strobe.wrRise   = busWrEn & hit[ADDR_RISE];
    strobe.wrFall   = busWrEn & hit[ADDR_FALL];
    strobe.wrIrqEn  = busWrEn & hit[ADDR_IRQEN];
    strobe.wrDmaSel = busWrEn & hit[ADDR_DMA];
  end

endmodule

// File: rtl/edge_irq_datapath.sv
module edge_irq_datapath
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] rawIn,
  input  logic [NUM_LINES-1:0] busWrData,
  input  ctrlStrobe_t          strobe,
  input  logic [NUM_LINES-1:0] dmaAck,
  output logic [NUM_LINES-1:0] busRdData,
  output logic [NUM_LINES-1:0] irqOut,
  output logic [NUM_LINES-1:0] dmaReq,
  output logic [NUM_LINES-1:0] flagsQ,
  output logic [NUM_LINES-1:0] riseEnQ,
  output logic [NUM_LINES-1:0] fallEnQ,
  output logic [NUM_LINES-1:0] syncNow,
  output logic [NUM_LINES-1:0] syncPrev
);

  logic [NUM_LINES-1:0] irqEnQ;
  logic [NUM_LINES-1:0] dmaSelQ;
  logic [NUM_LINES-1:0] qualEdge;
  logic [NUM_LINES-1:0] clrReq;

  edge_irq_sync #(
    .WIDTH (NUM_LINES),
    .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din (rawIn),
    .dout(syncNow)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= '0;
      riseEnQ  <= '0;
      fallEnQ  <= '0;
      irqEnQ   <= '0;
      dmaSelQ  <= '0;
    end else begin
      syncPrev <= syncNow;
      if (strobe.wrRise)   riseEnQ <= busWrData;
      if (strobe.wrFall)   fallEnQ <= busWrData;
      if (strobe.wrIrqEn)  irqEnQ  <= busWrData;
      if (strobe.wrDmaSel) dmaSelQ <= busWrData;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic flagBit;

    assign qualEdge[i] = (syncNow[i] & ~syncPrev[i] & riseEnQ[i])
                       | (~syncNow[i] & syncPrev[i] & fallEnQ[i]);
    assign clrReq[i]   = (strobe.clrFlags & busWrData[i]) | dmaAck[i];

    // A new qualifying edge takes priority over any clear in the same cycle.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagBit <= 1'b0;
      else       flagBit <= qualEdge[i] | (flagBit & ~clrReq[i]);
    end

    assign flagsQ[i] = flagBit;
    assign irqOut[i] = flagBit & irqEnQ[i];
    assign dmaReq[i] = flagBit & dmaSelQ[i];
  end

  always_comb begin
    busRdData = '0;
    if (strobe.rdHit[ADDR_FLAGS]) busRdData = flagsQ;
    if (strobe.rdHit[ADDR_RISE])  busRdData = riseEnQ;
    if (strobe.rdHit[ADDR_FALL])  busRdData = fallEnQ;
    if (strobe.rdHit[ADDR_IRQEN]) busRdData = irqEnQ;
    if (strobe.rdHit[ADDR_DMA])   busRdData = dmaSelQ;
  end

endmodule

// File: rtl/edge_irq_flags.sv
module edge_irq_flags
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = 16,
  parameter int unsigned NUM_NMI     = 2,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_LINES  = NUM_IRQ + NUM_NMI
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_IRQ-1:0]   irqIn,
  input  logic [NUM_NMI-1:0]   nmiIn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [NUM_LINES-1:0] busWrData,
  output logic [NUM_LINES-1:0] busRdData,
  input  logic [NUM_LINES-1:0] dmaAck,
  output logic [NUM_LINES-1:0] irqOut,
  output logic [NUM_LINES-1:0] dmaReq
);

  ctrlStrobe_t          strobe;
  logic [NUM_LINES-1:0] rawAll;
  logic [NUM_LINES-1:0] flagsQ;
  logic [NUM_LINES-1:0] riseEnQ;
  logic [NUM_LINES-1:0] fallEnQ;
  logic [NUM_LINES-1:0] syncNow;
  logic [NUM_LINES-1:0] syncPrev;

  assign rawAll = {nmiIn, irqIn};

  edge_irq_ctrl #(
    .ADDR_W(ADDR_W)
  ) ctrl_i (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  edge_irq_datapath #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .rawIn    (rawAll),
    .busWrData(busWrData),
    .strobe   (strobe),
    .dmaAck   (dmaAck),
    .busRdData(busRdData),
    .irqOut   (irqOut),
    .dmaReq   (dmaReq),
    .flagsQ   (flagsQ),
    .riseEnQ  (riseEnQ),
    .fallEnQ  (fallEnQ),
    .syncNow  (syncNow),
    .syncPrev (syncPrev)
  );

endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
  parameter int unsigned NUM_LINES = 18,
  parameter int unsigned ADDR_W    = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [NUM_LINES-1:0] busWrData,
  input logic [NUM_LINES-1:0] dmaAck,
  input logic [NUM_LINES-1:0] flagsQ,
  input logic [NUM_LINES-1:0] riseEnQ,
  input logic [NUM_LINES-1:0] fallEnQ,
  input logic [NUM_LINES-1:0] syncNow,
  input logic [NUM_LINES-1:0] syncPrev
);

  logic [NUM_LINES-1:0] busClr;
  logic [NUM_LINES-1:0] edgeSeen;

  always_comb begin
    busClr   = (busWrEn && busAddr == '0) ? busWrData : '0;
    edgeSeen = (syncNow & ~syncPrev & riseEnQ) | (~syncNow & syncPrev & fallEnQ);
  end

  // R4: a flag only turns on after a qualifying edge in the previous cycle
  assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((flagsQ & ~$past(flagsQ) & ~$past(edgeSeen)) == '0));

  // R10: a qualifying edge always leaves the flag set, clears notwithstanding
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (($past(edgeSeen) & ~flagsQ) == '0));

  // R8: bus clear without a competing edge empties the flag
  assert_bus_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (($past(busClr & ~edgeSeen) & flagsQ) == '0));

  // R9: DMA acknowledge without a competing edge empties the flag
  assert_dma_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (($past(dmaAck & ~edgeSeen) & flagsQ) == '0));

  // R12: a set flag drops only through a clear request
  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (($past(flagsQ & ~busClr & ~dmaAck) & ~flagsQ) == '0));

endmodule

bind edge_irq_flags edge_irq_chk #(
  .NUM_LINES(NUM_LINES),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .dmaAck   (dmaAck),
  .flagsQ   (flagsQ),
  .riseEnQ  (riseEnQ),
  .fallEnQ  (fallEnQ),
  .syncNow  (syncNow),
  .syncPrev (syncPrev)
);

// File: tb/edge_irq_flags_tb.sv
`timescale 1ns/1ps
module edge_irq_flags_tb_top;

  localparam int NI = 16;
  localparam int NN = 2;
  localparam int NL = NI + NN;
  localparam int AW = 3;
  localparam logic [NL-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] raw = '0;
  logic [NI-1:0] irqIn;
  logic [NN-1:0] nmiIn;
  logic [AW-1:0] busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [NL-1:0] busWrData = '0;
  logic [NL-1:0] busRdData;
  logic [NL-1:0] dmaAck = '0;
  logic [NL-1:0] irqOut;
  logic [NL-1:0] dmaReq;

  int checks = 0;
  int errors = 0;

  assign irqIn = raw[NI-1:0];
  assign nmiIn = raw[NL-1:NI];

  always #2.5 clk = ~clk;

  edge_irq_flags dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .nmiIn(nmiIn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .dmaAck(dmaAck), .irqOut(irqOut), .dmaReq(dmaReq)
  );

  // Behavioural expectation built from the requirements
  logic [NL-1:0] mS1, mS2, mPrev, mFlags, mRise, mFall, mIrqEn, mDma;

  function automatic logic [NL-1:0] nextFlags(logic [NL-1:0] f, logic [NL-1:0] s,
      logic [NL-1:0] p, logic [NL-1:0] re, logic [NL-1:0] fe, logic [NL-1:0] clr);
    logic [NL-1:0] q;
    q = (s & ~p & re) | (~s & p & fe);
    return q | (f & ~clr);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 <= '0; mS2 <= '0; mPrev <= '0; mFlags <= '0;
      mRise <= '0; mFall <= '0; mIrqEn <= '0; mDma <= '0;
    end else begin
      mFlags <= nextFlags(mFlags, mS2, mPrev, mRise, mFall,
                          dmaAck | ((busWrEn && busAddr == 3'd0) ? busWrData : '0));
      mPrev <= mS2; mS2 <= mS1; mS1 <= raw;
      if (busWrEn && busAddr == 3'd1) mRise  <= busWrData;
      if (busWrEn && busAddr == 3'd2) mFall  <= busWrData;
      if (busWrEn && busAddr == 3'd3) mIrqEn <= busWrData;
      if (busWrEn && busAddr == 3'd4) mDma   <= busWrData;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; dmaAck = '0; busAddr = '0; busWrData = '0;
    #0.5;
  endtask

  task automatic steps(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic busWrite(logic [AW-1:0] a, logic [NL-1:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    step();
  endtask

  task automatic readReg(string tag, logic [AW-1:0] a, logic [31:0] exp);
    @(negedge clk);
    busAddr = a;
    #0.5;
    check(tag, busRdData, exp);
    busAddr = '0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    steps(3);
    @(negedge clk); rstN = 1'b1; #0.5;

    // R1 reset state
    check("R1 flags", busRdData, 0);
    check("R1 irqOut", irqOut, 0);
    check("R1 dmaReq", dmaReq, 0);
    readReg("R1 rise", 3'd1, 0);
    readReg("R1 dma", 3'd4, 0);

    // R11 configuration and readback
    busWrite(3'd1, 18'h10005);
    busWrite(3'd2, 18'h20006);
    busWrite(3'd3, ALL);
    busWrite(3'd4, 18'h0000F);
    readReg("R11 rise", 3'd1, 32'h10005);
    readReg("R11 fall", 3'd2, 32'h20006);
    readReg("R11 irqen", 3'd3, 32'h3FFFF);
    readReg("R11 dmasel", 3'd4, 32'h0000F);
    readReg("R11 unmapped5", 3'd5, 0);
    readReg("R11 unmapped7", 3'd7, 0);
    @(negedge clk); #0.5;

    // R2 rising on line 0, R4 rising on line 3 with no enable
    raw = 18'h00009;
    steps(2);
    check("R2 not before third edge", busRdData, 0);
    step();
    check("R2 flag on third edge", busRdData, 32'h1);
    check("R6 irqOut", irqOut, 32'h1);
    check("R7 dmaReq", dmaReq, 32'h1);

    // R4 rising on fall-only line 1, then R3 falling on it
    raw = 18'h0000B;
    steps(4);
    check("R4 rising ignored", busRdData, 32'h1);
    raw = 18'h00009;
    steps(3);
    check("R3 falling flag", busRdData, 32'h3);

    // R5 both edges on line 2
    raw = 18'h0000D;
    steps(3);
    check("R5 rising", busRdData, 32'h7);
    busWrite(3'd0, 18'h4);
    check("R8 clear line2", busRdData, 32'h3);
    raw = 18'h00009;
    steps(3);
    check("R5 falling", busRdData, 32'h7);

    // R8 write of zeros, then partial clear
    busWrite(3'd0, 18'h0);
    check("R8 zero write", busRdData, 32'h7);
    busWrite(3'd0, 18'h2);
    check("R8 clear line1", busRdData, 32'h5);

    // R6 mask gates only the output
    busWrite(3'd3, 18'h3FFFE);
    check("R6 masked irqOut", irqOut, 32'h4);
    check("R6 flags kept", busRdData, 32'h5);
    check("R7 dmaReq", dmaReq, 32'h5);
    busWrite(3'd4, 18'h0);
    check("R7 dma deselected", dmaReq, 0);

    // R9 DMA acknowledge clears only its line
    dmaAck = 18'h4;
    step();
    check("R9 ack line2", busRdData, 32'h1);

    // R10 set wins on non-maskable line 0 (bit 16)
    raw = 18'h10009;
    steps(2);
    busAddr = 3'd0; busWrData = 18'h10000; busWrEn = 1'b1; dmaAck = 18'h10000;
    step();
    check("R10 set wins", busRdData, 32'h10001);

    // R3 and R4 on non-maskable line 1 (bit 17)
    raw = 18'h30009;
    steps(4);
    check("R4 nmi1 rising ignored", busRdData, 32'h10001);
    raw = 18'h10009;
    steps(3);
    check("R3 nmi1 falling", busRdData, 32'h30001);

    // R12 sticky while the lines wander with no clear
    raw = 18'h0;
    steps(5);
    check("R12 sticky", busRdData | 32'h4, 32'h30005);

    // Random traffic against the expectation model
    for (int it = 0; it < 600; it++) begin
      raw = NL'($urandom) & ALL;
      if (($urandom % 4) == 0) begin
        busAddr = AW'($urandom % 8);
        busWrData = NL'($urandom);
        busWrEn = 1'b1;
      end
      if (($urandom % 8) == 0) dmaAck = NL'($urandom);
      step();
      check("R12 flags", busRdData, mFlags);
      check("R6 irqOut", irqOut, mFlags & mIrqEn);
      check("R7 dmaReq", dmaReq, mFlags & mDma);
      if ((it % 50) == 0) readReg("R11 rise random", 3'd1, mRise);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule